// File: doc/BRIEF.md
# Unaligned Partial-Word Merge Unit

This block forms the merged word for the four unaligned partial-word operations: load-left, load-right, store-left and store-right. The requester supplies the operation, the effective address, the byte order, the current value of the destination register and the aligned memory word read at that address. For loads, the merged word goes back to the register file. For stores, it is written back to memory as a read-modify-write of the aligned word. A byte-lane mask comes with each store result so that a memory with byte writes can skip the full-word write.

The aligned address is driven combinationally. The merge is captured on the clock edge at which the request strobe is high, and it is then presented for one cycle with a valid pulse. A flag with the result says whether it is meant for the register file or for memory. A second flag says whether it may be committed: a load whose aligned read faulted must leave its register untouched. These operations never fault because of misalignment.

Top module: `partial_word_merge`

## Requirements
- R1: `word_addr` equals `addr` with its two low bits forced to zero, combinationally and in every cycle.
- R2: When `req` is high at a rising clock edge, the result of that cycle's inputs appears after that edge and `res_valid` is high for exactly the following cycle. `res_valid` is low after any edge where `req` is low, and the result outputs hold their values until the next request.
- R3: `op` encoding: 0 = load-left, 1 = load-right, 2 = store-left, 3 = store-right. `res_to_mem` is 0 for the two loads and 1 for the two stores.
- R4: Big-endian load-left, byte offset o (lane i is bits 8i+7:8i). Result lanes o..3 take memory lanes 0..3-o, and lanes below o keep the register. Offset 0 loads the whole word.
- R5: Big-endian load-right, offset o. Result lanes 0..o take memory lanes 3-o..3, and the lanes above keep the register. Offset 3 loads the whole word.
- R6: Big-endian store-left, offset o. Memory lanes 0..3-o take register lanes o..3, and the other memory lanes are kept. Offset 0 writes the whole register.
- R7: Big-endian store-right, offset o. Memory lanes 3-o..3 take register lanes 0..o, and the other memory lanes are kept. Offset 3 writes the whole register.
- R8: Little-endian loads. Load-left at offset o equals the big-endian pattern at offset 3-o. Load-right at offset 0 returns the register unchanged, and at offset o>0 it equals the big-endian pattern at offset 3-o.
- R9: Little-endian stores. Store-left and store-right at offset o equal the big-endian pattern at offset 3-o, so store-left offset 3 and store-right offset 0 write the whole register.
- R10: `res_byte_en` bit i is set exactly when a store writes register bytes into memory lane i. It is all zero for loads.
- R11: `res_commit` is 0 for a load whose `mem_fault` was high and 1 for every other result. Stores ignore `mem_fault`.
- R12: Asynchronous active-low reset clears `res_valid`, `res_to_mem`, `res_commit`, `res_data` and `res_byte_en` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request strobe; inputs are captured on this edge |
| op | input | 2 | Operation (0 load-left, 1 load-right, 2 store-left, 3 store-right) |
| addr | input | AW | Effective byte address |
| big_endian | input | 1 | 1 = big-endian lane order, 0 = little-endian |
| reg_val | input | 32 | Current value of the register operand |
| mem_word | input | 32 | Aligned memory word read at `word_addr` |
| mem_fault | input | 1 | The aligned read raised a fault |
| word_addr | output | AW | Word-aligned access address |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_to_mem | output | 1 | Result target: 0 register file, 1 memory |
| res_commit | output | 1 | Result may be written |
| res_data | output | 32 | Merged word |
| res_byte_en | output | 4 | Memory lanes written by a store |

## Verification
The aligned address has no register on its path, so the bench checks it one time step after each new address is driven, in the same cycle. Every other output sits behind a single register. The bench computes the expected merge from the inputs it drives while `req` is high and compares it at the falling edge that follows the next rising edge. On idle cycles it compares the held values and a low valid flag. Stimulus and comparison both happen at falling edges, one result per clock, so each expected value lines up with exactly the edge that captured it.

// File: rtl/partial_word_merge.sv
module partial_word_merge #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [1:0]    op,
  input  logic [AW-1:0] addr,
  input  logic          big_endian,
  input  logic [31:0]   reg_val,
  input  logic [31:0]   mem_word,
  input  logic          mem_fault,
  output logic [AW-1:0] word_addr,
  output logic          res_valid,
  output logic          res_to_mem,
  output logic          res_commit,
  output logic [31:0]   res_data,
  output logic [3:0]    res_byte_en
);

  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic [1:0]  ofs, eff;
  logic [5:0]  sh, shc;
  logic [31:0] merged;
  logic [3:0]  lanes;
  logic        is_store;

  assign word_addr = {addr[AW-1:2], 2'b00};
  assign ofs       = addr[1:0];
  assign eff       = big_endian ? ofs : ~ofs;
  assign sh        = {1'b0, eff, 3'b000};
  assign shc       = 6'd24 - sh;
  assign is_store  = op[1];

  always_comb begin
    merged = reg_val;
    lanes  = 4'b0000;
    case (op)
      2'd0: merged = (mem_word << sh) | (reg_val & ~(ONES << sh));
      2'd1: begin
        if (!big_endian && ofs == 2'd0) merged = reg_val;
        else merged = (mem_word >> shc) | (reg_val & (ONES << (sh + 6'd8)));
      end
      2'd2: begin
        merged = (reg_val >> sh) | (mem_word & ~(ONES >> sh));
        lanes  = 4'b1111 >> eff;
      end
      default: begin
        merged = (reg_val << shc) | (mem_word & ~(ONES << shc));
        lanes  = 4'b1111 << ~eff;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_to_mem  <= 1'b0;
      res_commit  <= 1'b0;
      res_data    <= '0;
      res_byte_en <= '0;
    end else begin
      res_valid <= req;
      if (req) begin
        res_to_mem  <= is_store;
        res_commit  <= is_store | ~mem_fault;
        res_data    <= merged;
        res_byte_en <= lanes;
      end
    end
  end

  assert_req_gives_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> res_valid);
  assert_idle_no_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !res_valid);
  assert_load_no_lanes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_to_mem) |-> (res_byte_en == 4'b0000));
  assert_store_edge_lane_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_to_mem) |-> (res_byte_en[0] || res_byte_en[3]));
  assert_store_commits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_to_mem) |-> res_commit);

endmodule

// File: tb/partial_word_merge_test.sv
module partial_word_merge_test;
  localparam int PERIOD = 10;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, big_endian = 1'b0, mem_fault = 1'b0;
  logic [1:0] op = '0;
  logic [AW-1:0] addr = '0;
  logic [31:0] reg_val = '0, mem_word = '0;
  logic [AW-1:0] word_addr;
  logic res_valid, res_to_mem, res_commit;
  logic [31:0] res_data;
  logic [3:0] res_byte_en;

  int errors = 0, checks = 0;
  logic exp_valid = 0, exp_to_mem = 0, exp_commit = 0;
  logic [31:0] exp_data = '0;
  logic [3:0] exp_be = '0;
  string exp_tag = "R12";

  always #(PERIOD/2) clk = ~clk;

  partial_word_merge #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr(addr),
    .big_endian(big_endian), .reg_val(reg_val), .mem_word(mem_word),
    .mem_fault(mem_fault), .word_addr(word_addr), .res_valid(res_valid),
    .res_to_mem(res_to_mem), .res_commit(res_commit), .res_data(res_data),
    .res_byte_en(res_byte_en));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input logic [1:0] o, input logic [1:0] offs, input logic big,
                       input logic [31:0] rv, input logic [31:0] mw,
                       output logic [31:0] d, output logic [3:0] be);
    int e;
    e = big ? int'(offs) : 3 - int'(offs);
    d = '0; be = '0;
    for (int j = 0; j < 4; j++) begin
      case (o)
        2'd0: d[8*j +: 8] = (j >= e) ? mw[8*(j-e) +: 8] : rv[8*j +: 8];
        2'd1: begin
          if (!big && offs == 2'd0) d[8*j +: 8] = rv[8*j +: 8];
          else d[8*j +: 8] = (j <= e) ? mw[8*(j+3-e) +: 8] : rv[8*j +: 8];
        end
        2'd2: begin
          be[j] = (j < 4 - e);
          d[8*j +: 8] = be[j] ? rv[8*(j+e) +: 8] : mw[8*j +: 8];
        end
        default: begin
          be[j] = (j >= 3 - e);
          d[8*j +: 8] = be[j] ? rv[8*(j-3+e) +: 8] : mw[8*j +: 8];
        end
      endcase
    end
  endtask

  task automatic compare_outputs();
    check("R2 valid", {31'b0, res_valid}, {31'b0, exp_valid});
    check("R3 target", {31'b0, res_to_mem}, {31'b0, exp_to_mem});
    check("R11 commit", {31'b0, res_commit}, {31'b0, exp_commit});
    check({exp_tag, " data"}, res_data, exp_data);
    check("R10 lanes", {28'b0, res_byte_en}, {28'b0, exp_be});
  endtask

  task automatic step(input logic r, input logic [1:0] o, input logic [AW-1:0] a,
                      input logic big, input logic [31:0] rv, input logic [31:0] mw,
                      input logic f);
    logic [31:0] d;
    logic [3:0] be;
    @(negedge clk);
    compare_outputs();
    req = r; op = o; addr = a; big_endian = big; reg_val = rv; mem_word = mw; mem_fault = f;
    #1;
    check("R1 aligned address", word_addr, {a[AW-1:2], 2'b00});
    exp_valid = r;
    if (r) begin
      model(o, a[1:0], big, rv, mw, d, be);
      exp_data = d; exp_be = be; exp_to_mem = o[1];
      exp_commit = o[1] | ~f;
      case ({big, o})
        3'b100: exp_tag = "R4"; 3'b101: exp_tag = "R5";
        3'b110: exp_tag = "R6"; 3'b111: exp_tag = "R7";
        3'b000, 3'b001: exp_tag = "R8";
        default: exp_tag = "R9";
      endcase
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R12: outputs cleared while reset is held
    compare_outputs();
    rst_n = 1'b1;
    // R4..R9 full sweep with two data patterns
    for (int b = 0; b < 2; b++)
      for (int o = 0; o < 4; o++)
        for (int k = 0; k < 4; k++) begin
          step(1'b1, 2'(o), 32'h1000_0000 + 32'(k), b[0], 32'hA1B2C3D4, 32'h11223344, 1'b0);
          step(1'b1, 2'(o), 32'h2000_0040 + 32'(k), b[0], 32'h0000_0000, 32'hFFFF_FFFF, 1'b0);
        end
    // R2: idle cycles hold results with no pulse
    step(1'b0, 2'd0, 32'h0000_0007, 1'b1, 32'h5555_5555, 32'hAAAA_AAAA, 1'b0);
    step(1'b0, 2'd3, 32'h0000_0002, 1'b0, 32'h1, 32'h2, 1'b1);
    // R11: faulted loads do not commit, faulted stores still do
    step(1'b1, 2'd0, 32'h0000_0001, 1'b1, 32'h1234_5678, 32'h9ABC_DEF0, 1'b1);
    step(1'b1, 2'd1, 32'h0000_0002, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0, 1'b1);
    step(1'b1, 2'd2, 32'h0000_0003, 1'b1, 32'h1234_5678, 32'h9ABC_DEF0, 1'b1);
    step(1'b1, 2'd3, 32'h0000_0000, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0, 1'b1);
    // mixed random traffic
    for (int i = 0; i < 400; i++)
      step(1'($urandom), 2'($urandom), $urandom, 1'($urandom), $urandom, $urandom, 1'($urandom));
    step(1'b0, 2'd0, 32'h0, 1'b0, 32'h0, 32'h0, 1'b0);
    step(1'b0, 2'd0, 32'h0, 1'b0, 32'h0, 32'h0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule